// File: doc/BRIEF.md
# Three-Phase Waveform Peak Detector

This block watches the signed voltage and current samples of the three phases of a power line. It keeps two magnitude registers: the largest absolute voltage and the largest absolute current seen during a measurement window. The window length is counted in half-line cycles, using a pulse from an external zero-crossing detector. When a window closes, the maxima gathered during that window are published and the gathering starts again from zero. Voltage and current are tracked independently over the phases picked by a peak mask. The published voltage peak and the published current peak may therefore come from different phases.

A second phase mask, also in the mode byte, picks the phases under threshold watch. A sample whose magnitude is strictly above the voltage level or the current level raises a sticky status bit for that phase and that quantity. A status bit stays set until a write-one-to-clear pulse removes it.

A small two-state controller runs the windows. It has two states:
- `S_OFF`: the window length is zero and the peak registers are frozen.
- `S_RUN`: a window is open.

It has these transitions:
- `T_ARM` (`S_OFF` to `S_RUN`): the length becomes non-zero. The half-cycle count and the running maxima are cleared.
- `T_CLOSE` (`S_RUN` to `S_RUN`): the closing half-cycle pulse arrives. The maxima are published and cleared.
- `T_STOP` (`S_RUN` to `S_OFF`): the length returns to zero.

Top module: `wave_peak_tracker`

## Requirements
- R1: After reset both peak outputs and all six status bits read zero.
- R2: Peaks hold sample magnitudes (absolute values). The most negative code, -2^(W-1), reads as 2^(W-1)-1.
- R3: Mode bits 2, 3 and 4 enable peak capture on phases A, B and C. The samples of a disabled phase never reach the peaks.
- R4: A window ends on the win_len-th half_cyc pulse counted from its start. Both peaks take the window maxima at that clock edge, and a valid sample in that same cycle is included. Between window ends the peaks keep their value.
- R5: The voltage maximum and the current maximum are each taken over all enabled phases independently of each other.
- R6: The running maxima restart from zero for each window, so a window with smaller samples lowers the published peak.
- R7: While win_len is zero the peaks do not change. When win_len turns non-zero, a new window opens with a count of zero and empty maxima. Samples in that arming cycle are not counted.
- R8: Mode bits 5, 6 and 7 enable threshold watch on phases A, B and C. A valid sample of a watched phase whose magnitude is strictly greater than v_lvl sets status bit 0, 1 or 2 for phase A, B or C. One strictly greater than i_lvl sets status bit 3, 4 or 5 for phase A, B or C.
- R9: A status bit stays set until a 1 arrives in the matching bit of stat_clr. A set in the same cycle as its clear wins.
- R10: When smp_valid is low, the samples affect neither the maxima nor the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| half_cyc | input | 1 | Half-line-cycle pulse |
| mode | input | 8 | [4:2] peak phase mask, [7:5] threshold phase mask, [1:0] unused |
| win_len | input | CW | Window length in half-line cycles, 0 freezes the peaks |
| v_lvl | input | W-1 | Voltage threshold magnitude |
| i_lvl | input | W-1 | Current threshold magnitude |
| v_a | input | W | Phase A voltage, signed |
| v_b | input | W | Phase B voltage, signed |
| v_c | input | W | Phase C voltage, signed |
| i_a | input | W | Phase A current, signed |
| i_b | input | W | Phase B current, signed |
| i_c | input | W | Phase C current, signed |
| stat_clr | input | 6 | Write-one-to-clear for status |
| v_peak | output | W-1 | Published voltage peak magnitude |
| i_peak | output | W-1 | Published current peak magnitude |
| status | output | 6 | Sticky threshold flags, voltage A..C in [2:0], current A..C in [5:3] |

## Verification
A half-cycle counter that slips shows up only when a window closes: the peaks change one pulse early or late, or change with no pulse at all. A running maximum that is not cleared shows one window later, as a peak that fails to drop. A controller stuck in the wrong state either freezes the peaks after win_len turns non-zero or lets them change while the length is zero. Status faults show in the very next cycle, as a bit that falls without a clear or rises without a watched, valid, over-level sample.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
    typedef enum logic {
        S_OFF = 1'b0,
        S_RUN = 1'b1
    } win_state_t;

    localparam int PHASES   = 3;
    localparam int PK_LSB   = 2;
    localparam int TH_LSB   = 5;
endpackage

// File: rtl/wpk_abs.sv
module wpk_abs #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] x,
    output logic        [W-2:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    logic [W-1:0] neg;

    always_comb begin
        neg = -x;
        if (x == MOST_NEG)
            mag = '1;
        else if (x[W-1])
            mag = neg[W-2:0];
        else
            mag = x[W-2:0];
    end
endmodule

// File: rtl/wpk_maxsel.sv
module wpk_maxsel #(
    parameter int MW = 15,
    parameter int N  = 3
) (
    input  logic [N-1:0][MW-1:0] mags,
    input  logic [N-1:0]         en,
    input  logic                 take,
    input  logic [MW-1:0]        cur,
    output logic [MW-1:0]        best
);
    always_comb begin
        best = cur;
        for (int p = 0; p < N; p++) begin
            if (take && en[p] && (mags[p] > best))
                best = mags[p];
        end
    end
endmodule

// File: rtl/wpk_window_ctl.sv
module wpk_window_ctl
    import wpk_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_cyc,
    input  logic [CW-1:0] win_len,
    output logic          win_arm,
    output logic          win_close,
    output logic          win_acc
);
    win_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW:0]   cnt_inc;
    logic          len_nz;

    assign len_nz  = (win_len != '0);
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: if (len_nz)  state_d = S_RUN;
            S_RUN: if (!len_nz) state_d = S_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        win_arm   = 1'b0;
        win_close = 1'b0;
        win_acc   = 1'b0;
        unique case (state_q)
            S_OFF: win_arm = len_nz;
            S_RUN: begin
                win_acc   = len_nz;
                win_close = len_nz && half_cyc && (cnt_inc >= {1'b0, win_len});
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (win_arm || win_close)
            cnt_q <= '0;
        else if (win_acc && half_cyc)
            cnt_q <= cnt_inc[CW-1:0];
    end
endmodule

// File: rtl/wave_peak_tracker.sv
module wave_peak_tracker
    import wpk_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic                 half_cyc,
    input  logic [7:0]           mode,
    input  logic [CW-1:0]        win_len,
    input  logic [W-2:0]         v_lvl,
    input  logic [W-2:0]         i_lvl,
    input  logic signed [W-1:0]  v_a,
    input  logic signed [W-1:0]  v_b,
    input  logic signed [W-1:0]  v_c,
    input  logic signed [W-1:0]  i_a,
    input  logic signed [W-1:0]  i_b,
    input  logic signed [W-1:0]  i_c,
    input  logic [2*PHASES-1:0]  stat_clr,
    output logic [W-2:0]         v_peak,
    output logic [W-2:0]         i_peak,
    output logic [2*PHASES-1:0]  status
);
    localparam int MW = W - 1;

    logic [PHASES-1:0][W-1:0]  v_raw, i_raw;
    logic [PHASES-1:0][MW-1:0] v_mag, i_mag;
    logic [PHASES-1:0]         pk_en, th_en;
    logic [MW-1:0]             v_run_q, i_run_q, v_best, i_best;
    logic [PHASES-1:0]         v_over, i_over;
    logic                      win_arm, win_close, win_acc;

    assign v_raw = {v_c, v_b, v_a};
    assign i_raw = {i_c, i_b, i_a};
    assign pk_en = mode[PK_LSB +: PHASES];
    assign th_en = mode[TH_LSB +: PHASES];

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_phase
            wpk_abs #(.W(W)) u_vabs (.x(v_raw[p]), .mag(v_mag[p]));
            wpk_abs #(.W(W)) u_iabs (.x(i_raw[p]), .mag(i_mag[p]));
            assign v_over[p] = smp_valid && th_en[p] && (v_mag[p] > v_lvl);
            assign i_over[p] = smp_valid && th_en[p] && (i_mag[p] > i_lvl);
        end
    endgenerate

    wpk_window_ctl #(.CW(CW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_cyc  (half_cyc),
        .win_len   (win_len),
        .win_arm   (win_arm),
        .win_close (win_close),
        .win_acc   (win_acc)
    );

    wpk_maxsel #(.MW(MW), .N(PHASES)) u_vmax (
        .mags (v_mag), .en (pk_en), .take (smp_valid && win_acc),
        .cur  (v_run_q), .best (v_best)
    );

    wpk_maxsel #(.MW(MW), .N(PHASES)) u_imax (
        .mags (i_mag), .en (pk_en), .take (smp_valid && win_acc),
        .cur  (i_run_q), .best (i_best)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_run_q <= '0;
            i_run_q <= '0;
            v_peak  <= '0;
            i_peak  <= '0;
        end else if (win_arm) begin
            v_run_q <= '0;
            i_run_q <= '0;
        end else if (win_close) begin
            v_peak  <= v_best;
            i_peak  <= i_best;
            v_run_q <= '0;
            i_run_q <= '0;
        end else if (win_acc) begin
            v_run_q <= v_best;
            i_run_q <= i_best;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~stat_clr) | {i_over, v_over};
    end
endmodule

// File: rtl/wpk_checker.sv
module wpk_checker #(
    parameter int W  = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          half_cyc,
    input logic [7:0]    mode,
    input logic [CW-1:0] win_len,
    input logic [5:0]    stat_clr,
    input logic [W-2:0]  v_peak,
    input logic [W-2:0]  i_peak,
    input logic [5:0]    status
);
    // R7: zero window length freezes the peaks
    p_frozen_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_len == '0) |=> ($stable(v_peak) && $stable(i_peak)));

    // R4: peaks move only at a half-cycle pulse
    p_move_on_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_cyc) |=> ($stable(v_peak) && $stable(i_peak)));

    // R9: a set bit survives unless cleared
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(stat_clr)) & ~status) == 6'd0));

    // R8: a rising bit needs its phase under watch
    p_watch_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status & ~$past(status)) &
                   ~{$past(mode[7:5]), $past(mode[7:5])}) == 6'd0));

    // R10: no strobe, no new flag
    p_need_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid) |=> ((status & ~$past(status)) == 6'd0));
endmodule

bind wave_peak_tracker wpk_checker #(.W(W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .half_cyc  (half_cyc),
    .mode      (mode),
    .win_len   (win_len),
    .stat_clr  (stat_clr),
    .v_peak    (v_peak),
    .i_peak    (i_peak),
    .status    (status)
);

// File: tb/sim_wave_peak_tracker.sv
module sim_wave_peak_tracker;
    localparam int W  = 16;
    localparam int CW = 8;
    localparam int MW = W - 1;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0, half_cyc = 1'b0;
    logic [7:0] mode = '0;
    logic [CW-1:0] win_len = '0;
    logic [MW-1:0] v_lvl = '1, i_lvl = '1;
    logic signed [W-1:0] v_a = '0, v_b = '0, v_c = '0, i_a = '0, i_b = '0, i_c = '0;
    logic [5:0] stat_clr = '0;
    logic [MW-1:0] v_peak, i_peak;
    logic [5:0] status;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    bit m_run;
    int m_cnt;
    int m_vmax, m_imax, m_vpk, m_ipk;
    logic [5:0] m_stat;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_peak_tracker #(.W(W), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .half_cyc(half_cyc),
        .mode(mode), .win_len(win_len), .v_lvl(v_lvl), .i_lvl(i_lvl),
        .v_a(v_a), .v_b(v_b), .v_c(v_c), .i_a(i_a), .i_b(i_b), .i_c(i_c),
        .stat_clr(stat_clr), .v_peak(v_peak), .i_peak(i_peak), .status(status)
    );

    function automatic int mag(logic signed [W-1:0] x);
        int r;
        r = int'(x);
        if (r < 0) r = -r;
        if (r > (1 << (W-1)) - 1) r = (1 << (W-1)) - 1;
        return r;
    endfunction

    task automatic model_reset();
        m_run = 0; m_cnt = 0; m_vmax = 0; m_imax = 0; m_vpk = 0; m_ipk = 0; m_stat = '0;
    endtask

    task automatic model_edge();
        int vm[3], im[3];
        int vc, ic;
        logic [5:0] setb;
        vm[0] = mag(v_a); vm[1] = mag(v_b); vm[2] = mag(v_c);
        im[0] = mag(i_a); im[1] = mag(i_b); im[2] = mag(i_c);
        setb = '0;
        for (int p = 0; p < 3; p++) begin
            if (smp_valid && mode[5+p] && vm[p] > int'(v_lvl)) setb[p] = 1'b1;
            if (smp_valid && mode[5+p] && im[p] > int'(i_lvl)) setb[3+p] = 1'b1;
        end
        m_stat = (m_stat & ~stat_clr) | setb;
        if (!m_run) begin
            if (win_len != 0) begin m_run = 1; m_cnt = 0; m_vmax = 0; m_imax = 0; end
        end else if (win_len == 0) begin
            m_run = 0;
        end else begin
            vc = m_vmax; ic = m_imax;
            for (int p = 0; p < 3; p++) begin
                if (smp_valid && mode[2+p]) begin
                    if (vm[p] > vc) vc = vm[p];
                    if (im[p] > ic) ic = im[p];
                end
            end
            if (half_cyc && (m_cnt + 1 >= int'(win_len))) begin
                m_vpk = vc; m_ipk = ic; m_vmax = 0; m_imax = 0; m_cnt = 0;
            end else begin
                m_vmax = vc; m_imax = ic;
                if (half_cyc) m_cnt++;
            end
        end
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at negedge with inputs set; returns at next negedge
    task automatic step(bit vld, bit hc);
        smp_valid = vld; half_cyc = hc;
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
        stat_clr = '0;
    endtask

    task automatic set_smp(int va, int vb, int vc, int ia, int ib, int ic);
        v_a = W'(va); v_b = W'(vb); v_c = W'(vc);
        i_a = W'(ia); i_b = W'(ib); i_c = W'(ic);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 v_peak", v_peak, 0);
        check("R1 i_peak", i_peak, 0);
        check("R1 status", status, 0);

        // R2/R3: phase A only; B carries larger values that must be ignored
        mode = 8'b000_001_00; win_len = 8'd2;
        step(0, 0);                                   // arm
        set_smp(-32768, 30000, 0, 100, -20000, 0);
        step(1, 0);
        set_smp(0, 0, 0, 0, 0, 0);
        step(0, 1);
        check("R4 no close after first pulse", v_peak, 0);
        step(0, 1);
        check("R2 saturated magnitude", v_peak, 32767);
        check("R3 phase B ignored", i_peak, 100);

        // R5: A and B enabled, peaks from different phases
        mode = 8'b000_011_00;
        set_smp(5, -7, 0, -900, 40, 0);
        step(1, 0);
        set_smp(0, 0, 0, 0, 0, 0);
        step(0, 1);
        set_smp(2, 1, 0, 3, 4, 0);
        step(1, 1);                                   // closing-cycle sample included
        check("R5 voltage from B", v_peak, 7);
        check("R5 current from A", i_peak, 900);

        // R6: smaller window lowers peak
        set_smp(3, 0, 0, 0, 1, 0);
        step(1, 1);
        step(0, 1);
        check("R6 voltage lowered", v_peak, 3);
        check("R6 current lowered", i_peak, 1);

        // R7: zero length freezes peaks
        win_len = 8'd0;
        set_smp(20000, 20000, 0, 20000, 20000, 0);
        for (int k = 0; k < 6; k++) step(1, 1);
        check("R7 voltage frozen", v_peak, 3);
        check("R7 current frozen", i_peak, 1);
        // R7/R4: re-arm with length 1, arming-cycle sample discarded
        win_len = 8'd1;
        step(1, 1);
        set_smp(0, 0, 0, 0, 0, 0);
        step(0, 1);
        check("R7 arm sample dropped", v_peak, 0);

        // R10: no strobe, no capture, no flag
        mode = 8'b111_111_00; v_lvl = 15'd10; i_lvl = 15'd10;
        set_smp(30000, 30000, 30000, 30000, 30000, 30000);
        step(0, 1);
        check("R10 peak untouched", v_peak, 0);
        check("R10 status untouched", status, 0);

        // R8: strict threshold on watched phases
        mode = 8'b110_000_00; v_lvl = 15'd1000; i_lvl = 15'd1999;
        set_smp(5000, 1000, 0, 5000, 0, -2000);
        step(1, 0);
        check("R8 equal level and unwatched A", status, 6'b100_000);
        v_b = 16'sd1001;
        step(1, 0);
        check("R8 voltage B over", status, 6'b100_010);

        // R9: set wins over clear; plain clear removes bit
        set_smp(0, 0, 0, 0, 0, -2000);
        stat_clr = 6'b100_010;
        step(1, 0);
        check("R9 set beats clear", status, 6'b100_000);
        set_smp(0, 0, 0, 0, 0, 0);
        step(1, 0);
        check("R9 sticky", status, 6'b100_000);
        stat_clr = 6'b100_000;
        step(1, 0);
        check("R9 cleared", status, 6'b000_000);

        // random phase against reference model (R4, R8 tags)
        for (int n = 0; n < 4000; n++) begin
            int sel;
            if (($urandom % 40) == 0) mode = 8'($urandom);
            if (($urandom % 60) == 0) begin
                sel = $urandom % 5;
                win_len = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd1 : (sel == 2) ? 8'd2 :
                          (sel == 3) ? 8'd3 : 8'd5;
            end
            if (($urandom % 50) == 0) begin
                v_lvl = 15'($urandom); i_lvl = 15'($urandom);
            end
            v_a = 16'($urandom); v_b = 16'($urandom); v_c = 16'($urandom);
            i_a = 16'($urandom); i_b = 16'($urandom); i_c = 16'($urandom);
            if (($urandom % 97) == 0) v_a = 16'sh8000;
            stat_clr = 6'($urandom) & 6'($urandom);
            step(($urandom % 3) != 0, ($urandom % 4) == 0);
            check("R4 random v_peak", v_peak, m_vpk);
            check("R4 random i_peak", i_peak, m_ipk);
            check("R8 random status", status, m_stat);
        end

        finish_run();
    end
endmodule